// File: doc/BRIEF.md
# Full/Empty Tagged Operand Register Bank

This block is the operand store of one compute tile in a dataflow fabric. It holds several independent register-file banks. Each bank has one read port and one write port. Every entry carries a full/empty flag, so each entry acts as a one-deep synchronizing slot:

- A read is taken only from a full entry, and it empties that entry.
- A write is taken only into an empty entry, and it fills that entry.

A producer therefore cannot overwrite an operand before it is consumed, and a consumer can never pick up a stale value. Every request is held off until its condition holds.

Three requesters share the bank array. The first is one read channel. The second is a local write channel fed by the tile itself. The third is a remote write channel fed by the network side, so neighbouring tiles can write into the store. Each channel uses a valid/ready handshake, and ready is decided in the same cycle as the request. Only one writer can use a bank's write port in a given cycle. When both writers aim at the same bank, the remote writer owns the port and the local writer waits. A synchronous clear input and the asynchronous reset both return every entry to empty.

Top module: `opnd_regbank`

## Requirements
- R1: The store has NUM_BANKS banks (default 8) of DEPTH entries (default 64). An entry is selected by a bank number and an index within that bank, and writing one entry never changes the contents or the flag of any other entry.
- R2: After reset every entry is empty, so a read of any entry is refused (rd_ready low).
- R3: A read is accepted (rd_ready high) only when rd_valid is high and the addressed entry is full. In that cycle rd_data shows the last value written to the entry.
- R4: A write on either channel is accepted only when the addressed entry is empty and the channel owns the bank's write port. At the following clock edge the entry becomes full and holds the written data.
- R5: An accepted read empties its entry at that clock edge. Afterwards, a second read of the entry is refused and a write into it is accepted.
- R6: A read and a write that address the same entry in one cycle are both judged on the entry's state before that cycle. If the entry is full, the read is accepted and the write is refused. If the entry is empty, the read is refused and the write is accepted.
- R7: When local and remote writes address the same bank in one cycle, loc_ready is low whatever the remote write's outcome. The remote write is judged on its own entry.
- R8: Local and remote writes to different banks are judged independently, and both may be accepted in the same cycle.
- R9: While clr is high no request is accepted. After a cycle with clr high, every entry is empty.
- R10: A refused request changes no entry, neither its data nor its flag. The same request presented again is accepted as soon as its condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, empties all entries |
| clr | input | 1 | Synchronous clear of all full flags, blocks all requests |
| rd_valid | input | 1 | Read request |
| rd_bank | input | BANK_W | Read bank number |
| rd_idx | input | IDX_W | Read entry index |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_data | output | DATA_W | Data of the addressed entry |
| loc_valid | input | 1 | Local write request |
| loc_bank | input | BANK_W | Local write bank number |
| loc_idx | input | IDX_W | Local write entry index |
| loc_data | input | DATA_W | Local write data |
| loc_ready | output | 1 | Local write accepted this cycle |
| rem_valid | input | 1 | Remote write request |
| rem_bank | input | BANK_W | Remote write bank number |
| rem_idx | input | IDX_W | Remote write entry index |
| rem_data | input | DATA_W | Remote write data |
| rem_ready | output | 1 | Remote write accepted this cycle |

## Verification
A read and a write can land on the same entry in the same cycle. Each can fire only in the state that the other one leaves behind, so that collision is the case most likely to break. The bench provokes it deliberately on a full entry and on an empty entry, with the writer taken from each channel. It then judges the outcome from the three ready outputs of that cycle and from a follow-up read that shows whether the entry ended full or empty and with which data. The same-bank clash between the two writers is also forced, both with the remote write accepted and with it refused. A long random mix of all channels and the clear input is checked cycle by cycle against a flag-and-data model kept in the bench.

// File: rtl/orb_pkg.sv
package orb_pkg;

  // Source that owns one bank's write port in a cycle.
  typedef enum logic [1:0] {
    WSRC_NONE   = 2'd0,
    WSRC_LOCAL  = 2'd1,
    WSRC_REMOTE = 2'd2
  } wsrc_e;

  // Width of a select field covering n items (at least 1 bit).
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Port ownership: the remote side takes precedence over the local side.
  function automatic wsrc_e pick_writer(input logic rem_hit, input logic loc_hit);
    if (rem_hit)      return WSRC_REMOTE;
    else if (loc_hit) return WSRC_LOCAL;
    else              return WSRC_NONE;
  endfunction

  // A read may fire on a full slot, a write on an empty one; clear blocks both.
  function automatic logic slot_readable(input logic req, input logic full, input logic clr);
    return req & full & ~clr;
  endfunction

  function automatic logic slot_writable(input logic req, input logic full, input logic clr);
    return req & ~full & ~clr;
  endfunction

endpackage

// File: rtl/orb_wr_arb.sv
module orb_wr_arb
  import orb_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic                 rem_valid,
  input  logic [BANK_W-1:0]    rem_bank,
  input  logic                 loc_valid,
  input  logic [BANK_W-1:0]    loc_bank,
  output logic [NUM_BANKS-1:0] rem_sel,
  output logic [NUM_BANKS-1:0] loc_sel,
  output logic                 loc_blocked
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic  rem_hit;
    logic  loc_hit;
    wsrc_e owner;
    assign rem_hit    = rem_valid && (rem_bank == BANK_W'(b));
    assign loc_hit    = loc_valid && (loc_bank == BANK_W'(b));
    assign owner      = pick_writer(rem_hit, loc_hit);
    assign rem_sel[b] = (owner == WSRC_REMOTE);
    assign loc_sel[b] = (owner == WSRC_LOCAL);
  end

  assign loc_blocked = loc_valid && rem_valid && (loc_bank == rem_bank);

endmodule

// File: rtl/orb_bank.sv
module orb_bank
  import orb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ok,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data
);

  logic [DEPTH-1:0]  full_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              rd_full;
  logic              wr_full;

  assign rd_full = full_q[rd_idx];
  assign wr_full = full_q[wr_idx];

  // Both decisions use the flags as they stood before this cycle's edge.
  assign rd_ok   = slot_readable(rd_en, rd_full, clr);
  assign wr_ok   = slot_writable(wr_en, wr_full, clr);
  assign rd_data = mem_q[rd_idx];

  // A read and a write can never both fire on one slot, so the order is free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
    end else if (clr) begin
      full_q <= '0;
    end else begin
      if (rd_ok) full_q[rd_idx] <= 1'b0;
      if (wr_ok) full_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_idx] <= wr_data;
  end

endmodule

// File: rtl/opnd_regbank.sv
module opnd_regbank
  import orb_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 32,
  localparam int BANK_W   = sel_width(NUM_BANKS),
  localparam int IDX_W    = sel_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_valid,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              loc_valid,
  input  logic [BANK_W-1:0] loc_bank,
  input  logic [IDX_W-1:0]  loc_idx,
  input  logic [DATA_W-1:0] loc_data,
  output logic              loc_ready,
  input  logic              rem_valid,
  input  logic [BANK_W-1:0] rem_bank,
  input  logic [IDX_W-1:0]  rem_idx,
  input  logic [DATA_W-1:0] rem_data,
  output logic              rem_ready
);

  // Named internal events, visible to the bound checker.
  logic [NUM_BANKS-1:0] rem_sel;
  logic [NUM_BANKS-1:0] loc_sel;
  logic                 loc_blocked;
  logic [NUM_BANKS-1:0] wr_ok;
  logic [NUM_BANKS-1:0] rd_ok;
  logic [DATA_W-1:0]    bank_rd_data [NUM_BANKS];

  orb_wr_arb #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_arb (
    .rem_valid   (rem_valid),
    .rem_bank    (rem_bank),
    .loc_valid   (loc_valid),
    .loc_bank    (loc_bank),
    .rem_sel     (rem_sel),
    .loc_sel     (loc_sel),
    .loc_blocked (loc_blocked)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              rd_en;

    assign wr_en   = rem_sel[b] | loc_sel[b];
    assign wr_idx  = rem_sel[b] ? rem_idx  : loc_idx;
    assign wr_data = rem_sel[b] ? rem_data : loc_data;
    assign rd_en   = rd_valid && (rd_bank == BANK_W'(b));

    orb_bank #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .wr_ok   (wr_ok[b]),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .rd_ok   (rd_ok[b]),
      .rd_data (bank_rd_data[b])
    );
  end

  assign rd_ready  = |rd_ok;
  assign rem_ready = |(wr_ok & rem_sel);
  assign loc_ready = |(wr_ok & loc_sel);

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_bank == BANK_W'(b)) rd_data = bank_rd_data[b];
    end
  end

endmodule

// File: rtl/orb_chk.sv
module orb_chk #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  parameter int BANK_W    = 3,
  parameter int IDX_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              rd_valid,
  input logic [BANK_W-1:0] rd_bank,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              loc_valid,
  input logic [BANK_W-1:0] loc_bank,
  input logic [IDX_W-1:0]  loc_idx,
  input logic              loc_ready,
  input logic              rem_valid,
  input logic [BANK_W-1:0] rem_bank,
  input logic [IDX_W-1:0]  rem_idx,
  input logic [DATA_W-1:0] rem_data,
  input logic              rem_ready,
  input logic              loc_blocked,
  input logic [NUM_BANKS-1:0] wr_ok
);

  // R7: a same-bank clash always stalls the local writer
  p_remote_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loc_blocked |-> !loc_ready);

  // R8: at most two bank write ports fire, one per channel
  p_two_writers_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_ok) <= 2);

  // R9: clear blocks every channel
  p_clr_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !(rd_ready || loc_ready || rem_ready));

  // R9: after a clear nothing is readable
  p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rd_ready);

  // R4: an accepted remote write is readable with its data on the next cycle
  p_write_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_valid && rem_ready) |=>
      (!(rd_valid && !clr && rd_bank == $past(rem_bank) && rd_idx == $past(rem_idx))
       || (rd_ready && rd_data == $past(rem_data))));

  // R5: an entry just read accepts an unopposed local write on the next cycle
  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=>
      (!(loc_valid && !clr && !loc_blocked && loc_bank == $past(rd_bank)
         && loc_idx == $past(rd_idx)) || loc_ready));

endmodule

bind opnd_regbank orb_chk #(
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W),
  .BANK_W    (BANK_W),
  .IDX_W     (IDX_W)
) u_orb_chk (.*);

// File: tb/tb_opnd_regbank.sv
`timescale 1ns/1ps
module tb_opnd_regbank;

  localparam int NB = 4;
  localparam int DP = 8;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          rd_valid = 1'b0;
  logic [BW-1:0] rd_bank = '0;
  logic [IW-1:0] rd_idx = '0;
  logic          rd_ready;
  logic [DW-1:0] rd_data;
  logic          loc_valid = 1'b0;
  logic [BW-1:0] loc_bank = '0;
  logic [IW-1:0] loc_idx = '0;
  logic [DW-1:0] loc_data = '0;
  logic          loc_ready;
  logic          rem_valid = 1'b0;
  logic [BW-1:0] rem_bank = '0;
  logic [IW-1:0] rem_idx = '0;
  logic [DW-1:0] rem_data = '0;
  logic          rem_ready;

  always #4 clk = ~clk;

  opnd_regbank #(.NUM_BANKS(NB), .DEPTH(DP), .DATA_W(DW)) dut (.*);

  // Reference state derived from the requirements.
  bit            m_full [NB][DP];
  logic [DW-1:0] m_data [NB][DP];
  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  function automatic logic [DW-1:0] pat(input int b, input int i, input int g);
    return DW'(b * 4099 + i * 37 + g * 911 + 5);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check readies and data, then update the model.
  task automatic cyc(input string tag,
                     input int rv, input int rb, input int ri,
                     input int lv, input int lb, input int li, input int ld,
                     input int mv, input int mb, input int mi, input int md,
                     input int c);
    bit er, el, em;
    @(negedge clk);
    rd_valid = rv[0]; rd_bank = rb[BW-1:0]; rd_idx = ri[IW-1:0];
    loc_valid = lv[0]; loc_bank = lb[BW-1:0]; loc_idx = li[IW-1:0]; loc_data = ld[DW-1:0];
    rem_valid = mv[0]; rem_bank = mb[BW-1:0]; rem_idx = mi[IW-1:0]; rem_data = md[DW-1:0];
    clr = c[0];
    #1;
    er = rv[0] && !c[0] && m_full[rb][ri];
    em = mv[0] && !c[0] && !m_full[mb][mi];
    el = lv[0] && !c[0] && !(mv[0] && mb == lb) && !m_full[lb][li];
    chk(tag, "rd_ready", int'(rd_ready), int'(er));
    chk(tag, "rem_ready", int'(rem_ready), int'(em));
    chk(tag, "loc_ready", int'(loc_ready), int'(el));
    if (er) chk(tag, "rd_data", int'(rd_data), int'(m_data[rb][ri]));
    @(posedge clk);
    if (c[0]) begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < DP; i++) m_full[b][i] = 1'b0;
    end else begin
      if (er) m_full[rb][ri] = 1'b0;
      if (em) begin m_full[mb][mi] = 1'b1; m_data[mb][mi] = md[DW-1:0]; end
      if (el) begin m_full[lb][li] = 1'b1; m_data[lb][li] = ld[DW-1:0]; end
    end
  endtask

  task automatic idle();
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < DP; i++) begin m_full[b][i] = 1'b0; m_data[b][i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: every entry refuses a read after reset
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < DP; i++) cyc("R2", 1, b, i, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R4/R8: fill all entries, remote and local into different banks at once
    for (int i = 0; i < DP; i++) begin
      cyc("R8", 0, 0, 0, 1, 1, i, pat(1, i, 0), 1, 0, i, pat(0, i, 0), 0);
      cyc("R8", 0, 0, 0, 1, 3, i, pat(3, i, 0), 1, 2, i, pat(2, i, 0), 0);
    end
    // R1/R3: sweep reads return each entry's own data
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < DP; i++) cyc("R1", 1, b, i, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: a second read is refused
    for (int b = 0; b < NB; b++) cyc("R5", 1, b, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R10: write stalled on a full entry, then succeeds once read
    cyc("R4", 0, 0, 0, 1, 2, 5, 16'h1111, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R10", 0, 0, 0, 1, 2, 5, 16'h2222, 0, 0, 0, 0, 0);
    cyc("R3", 1, 2, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 1, 2, 5, 16'h2222, 0, 0, 0, 0, 0);
    cyc("R3", 1, 2, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: read stalled on an empty entry until written
    for (int k = 0; k < 3; k++) cyc("R10", 1, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 1, 1, 6, 0, 0, 0, 0, 1, 1, 6, 16'h3333, 0);
    cyc("R10", 1, 1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6: same entry read+write, entry empty: read refused, write taken
    cyc("R6", 1, 0, 3, 1, 0, 3, 16'h4444, 0, 0, 0, 0, 0);
    // R6: same entry read+write, entry full: read taken, write refused
    cyc("R6", 1, 0, 3, 0, 0, 0, 0, 1, 0, 3, 16'h5555, 0);
    cyc("R6", 1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R7: same bank clash, remote accepted, local stalled
    cyc("R7", 0, 0, 0, 1, 3, 1, 16'h6666, 1, 3, 2, 16'h7777, 0);
    // R7: same bank clash, remote refused (full), local still stalled
    cyc("R7", 0, 0, 0, 1, 3, 1, 16'h6666, 1, 3, 2, 16'h8888, 0);
    cyc("R7", 1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R9: clear blocks all channels and empties everything
    cyc("R4", 0, 0, 0, 1, 1, 1, 16'h9999, 1, 2, 2, 16'haaaa, 0);
    cyc("R9", 1, 1, 1, 1, 0, 0, 16'h1, 1, 3, 3, 16'h2, 1);
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < DP; i++) cyc("R9", 1, b, i, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R10: random mix of all channels and clear
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom);
      cyc("R10", int'($urandom_range(0, 1)), int'($urandom_range(0, NB-1)),
          int'($urandom_range(0, DP-1)),
          int'($urandom_range(0, 1)), int'($urandom_range(0, NB-1)),
          int'($urandom_range(0, DP-1)), r & 16'hffff,
          int'($urandom_range(0, 1)), int'($urandom_range(0, NB-1)),
          int'($urandom_range(0, DP-1)), (r >>> 16) & 16'hffff,
          int'($urandom_range(0, 63) == 0));
    end
    idle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule